// File: doc/BRIEF.md
# Protected Clock-Control Register

This block is one byte-wide control register on the CPU's peripheral bus. It holds two live fields. The first picks how many wait states a special-function-register access takes while the PLL clock runs. The second picks the watchdog counter's clock source and locks that choice once it has been made.

A write lands only when an unlock bit from a separate protection register is high. The wait-state field is also frozen while the PLL is enabled, so the access timing cannot shift under a running PLL. Once software sets the watchdog source field, only reset can clear it. While that field is set, the block does three things:
- it asks the ring oscillator to run;
- it blocks writes to the stop-mode bit held in a neighbouring clock register;
- it tells the watchdog to keep counting through wait and hold states.

Reads are combinational and have no side effects.

Top module: `clkctl_guard_reg`

## Requirements
- R1: After a synchronous reset both fields are 0, so a read at the register address returns 0x00 and every control output is 0.
- R2: A write strobe while `unlock_i` is 0 changes neither field.
- R3: With `unlock_i` 1 and `pll_on_i` 0, a write at the register address loads bit 0 of the write data into the wait-state field on the next clock edge. `sfr_one_wait` is 1 for one wait and 0 for two waits.
- R4: While `pll_on_i` is 1, the wait-state field keeps its value on any write, but bit 2 of the same write is still accepted.
- R5: Writing 1 to bit 2 sets the watchdog source lock. A later write of 0 leaves it at 1, and only reset clears it.
- R6: When the lock bit is 1, `wdt_src_ring`, `ring_osc_req`, `stop_bit_wr_block` and `wdt_keep_in_idle` are all 1. When it is 0, all four are 0.
- R7: The readback places the wait-state field at bit 0 and the lock at bit 2. Bits 1, 3, 4 and 7 to 5 always read 0, whatever was written to them.
- R8: The register responds only at address `REG_ADDR` (default 0x01E). Writes elsewhere change nothing, and reads elsewhere return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data byte |
| unlock_i | input | 1 | Write permission from the protection register |
| pll_on_i | input | 1 | PLL enabled status |
| rd_data | output | 8 | Combinational read data |
| sfr_one_wait | output | 1 | 1 selects one wait, 0 selects two waits |
| wdt_src_ring | output | 1 | Watchdog counts the ring oscillator clock |
| ring_osc_req | output | 1 | Request to run the ring oscillator |
| stop_bit_wr_block | output | 1 | Blocks writes to the stop-mode bit of the neighbour clock register |
| wdt_keep_in_idle | output | 1 | Watchdog keeps counting in wait and hold states |

## Verification
A wrong wait-state field appears at `sfr_one_wait` and at readback bit 0 one edge after the faulty write. A missed lock, or a lock that clears, shows the same edge on all four watchdog-side outputs and on bit 2. Leaks through the gating appear at the first edge after the offending strobe: a write landing while locked out, while the PLL is on, or at a foreign address. Each is caught by reading back right after that edge. A stale or nonzero reserved bit shows at once on `rd_data`, because the read path has no register stage.

// File: rtl/clkctl_guard_pkg.sv
package clkctl_guard_pkg;

    localparam int DATA_W   = 8;
    localparam int WAIT_BIT = 0;
    localparam int LOCK_BIT = 2;

    typedef struct packed {
        logic lock;
        logic one_wait;
    } ctl_fields_t;

    typedef struct packed {
        logic src_ring;
        logic osc_req;
        logic stop_block;
        logic keep_idle;
    } wdt_ctl_t;

    function automatic logic [DATA_W-1:0] pack_view(input ctl_fields_t f);
        logic [DATA_W-1:0] v;
        v           = '0;
        v[WAIT_BIT] = f.one_wait;
        v[LOCK_BIT] = f.lock;
        return v;
    endfunction

    function automatic wdt_ctl_t derive_wdt(input logic lock);
        wdt_ctl_t c;
        c.src_ring   = lock;
        c.osc_req    = lock;
        c.stop_block = lock;
        c.keep_idle  = lock;
        return c;
    endfunction

endpackage

// File: rtl/ctl_access_decode.sv
module ctl_access_decode #(
    parameter int          ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] REG_ADDR = 10'h01E
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              unlock_i,
    output logic              hit_o,
    output logic              wr_ok_o
);
    always_comb begin
        hit_o   = (bus_addr == REG_ADDR);
        wr_ok_o = hit_o && bus_wr && unlock_i;
    end
endmodule

// File: rtl/ctl_wait_field.sv
module ctl_wait_field (
    input  logic clk,
    input  logic rst,
    input  logic wr_ok_i,
    input  logic pll_on_i,
    input  logic wdata_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= 1'b0;
        else if (wr_ok_i && !pll_on_i)
            q_o <= wdata_i;
    end
endmodule

// File: rtl/ctl_lock_field.sv
module ctl_lock_field (
    input  logic clk,
    input  logic rst,
    input  logic wr_ok_i,
    input  logic wdata_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= 1'b0;
        else if (wr_ok_i && wdata_i)
            q_o <= 1'b1;
    end
endmodule

// File: rtl/clkctl_guard_reg.sv
module clkctl_guard_reg
    import clkctl_guard_pkg::*;
#(
    parameter int          ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] REG_ADDR = 10'h01E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              unlock_i,
    input  logic              pll_on_i,
    output logic [7:0]        rd_data,
    output logic              sfr_one_wait,
    output logic              wdt_src_ring,
    output logic              ring_osc_req,
    output logic              stop_bit_wr_block,
    output logic              wdt_keep_in_idle
);
    logic        hit;
    logic        wr_ok;
    ctl_fields_t fields;
    wdt_ctl_t    wdt_ctl;

    ctl_access_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .unlock_i (unlock_i),
        .hit_o    (hit),
        .wr_ok_o  (wr_ok)
    );

    ctl_wait_field u_wait (
        .clk      (clk),
        .rst      (rst),
        .wr_ok_i  (wr_ok),
        .pll_on_i (pll_on_i),
        .wdata_i  (bus_wdata[WAIT_BIT]),
        .q_o      (fields.one_wait)
    );

    ctl_lock_field u_lock (
        .clk     (clk),
        .rst     (rst),
        .wr_ok_i (wr_ok),
        .wdata_i (bus_wdata[LOCK_BIT]),
        .q_o     (fields.lock)
    );

    always_comb begin
        wdt_ctl           = derive_wdt(fields.lock);
        rd_data           = hit ? pack_view(fields) : '0;
        sfr_one_wait      = fields.one_wait;
        wdt_src_ring      = wdt_ctl.src_ring;
        ring_osc_req      = wdt_ctl.osc_req;
        stop_bit_wr_block = wdt_ctl.stop_block;
        wdt_keep_in_idle  = wdt_ctl.keep_idle;
    end
endmodule

// File: rtl/clkctl_guard_chk.sv
module clkctl_guard_chk #(
    parameter int          ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] REG_ADDR = 10'h01E
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              unlock_i,
    input logic              pll_on_i,
    input logic [7:0]        rd_data,
    input logic              sfr_one_wait,
    input logic              wdt_src_ring,
    input logic              ring_osc_req,
    input logic              stop_bit_wr_block,
    input logic              wdt_keep_in_idle
);
    p_locked_out_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !unlock_i) |=> ($stable(sfr_one_wait) && $stable(wdt_src_ring)));

    p_wait_load_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && unlock_i && !pll_on_i && bus_addr == REG_ADDR)
        |=> (sfr_one_wait == $past(bus_wdata[0])));

    p_pll_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        pll_on_i |=> $stable(sfr_one_wait));

    p_sticky_lock_r5: assert property (@(posedge clk) disable iff (rst)
        wdt_src_ring |=> wdt_src_ring);

    p_wdt_group_r6: assert property (@(posedge clk) disable iff (rst)
        $countones({ring_osc_req, stop_bit_wr_block, wdt_keep_in_idle})
        == (wdt_src_ring ? 3 : 0));

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_data[7:3] == 5'b0) && !rd_data[1]);

    p_foreign_read_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != REG_ADDR) |-> (rd_data == 8'h00));

    p_readback_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_ADDR) |-> (rd_data[0] == sfr_one_wait && rd_data[2] == wdt_src_ring));
endmodule

bind clkctl_guard_reg clkctl_guard_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .bus_addr          (bus_addr),
    .bus_wr            (bus_wr),
    .bus_wdata         (bus_wdata),
    .unlock_i          (unlock_i),
    .pll_on_i          (pll_on_i),
    .rd_data           (rd_data),
    .sfr_one_wait      (sfr_one_wait),
    .wdt_src_ring      (wdt_src_ring),
    .ring_osc_req      (ring_osc_req),
    .stop_bit_wr_block (stop_bit_wr_block),
    .wdt_keep_in_idle  (wdt_keep_in_idle)
);

// File: tb/tb_clkctl_guard_reg.sv
`timescale 1ns/1ps
module tb_clkctl_guard_reg;
    localparam int          ADDR_W = 10;
    localparam logic [9:0]  REG_A  = 10'h01E;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_wr;
    logic [7:0]        bus_wdata;
    logic              unlock_i;
    logic              pll_on_i;
    logic [7:0]        rd_data;
    logic sfr_one_wait, wdt_src_ring, ring_osc_req, stop_bit_wr_block, wdt_keep_in_idle;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    clkctl_guard_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_A)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .unlock_i(unlock_i), .pll_on_i(pll_on_i),
        .rd_data(rd_data), .sfr_one_wait(sfr_one_wait), .wdt_src_ring(wdt_src_ring),
        .ring_osc_req(ring_osc_req), .stop_bit_wr_block(stop_bit_wr_block),
        .wdt_keep_in_idle(wdt_keep_in_idle)
    );

    typedef struct packed {
        logic [9:0] addr;
        logic       unl;
        logic       pll;
        logic [7:0] data;
        logic       exp_wait;
        logic       exp_lock;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{10'h01E, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0},  // R2 locked out
        '{10'h01E, 1'b1, 1'b0, 8'h01, 1'b1, 1'b0},  // R3 load one wait
        '{10'h01E, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0},  // R4 frozen by PLL
        '{10'h01E, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},  // R3 back to two waits
        '{10'h01E, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0},  // R4 frozen by PLL
        '{10'h01E, 1'b1, 1'b1, 8'h04, 1'b0, 1'b1},  // R4/R5 lock set with PLL on
        '{10'h01E, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},  // R5 lock not cleared
        '{10'h01E, 1'b1, 1'b0, 8'hFB, 1'b1, 1'b1},  // R7 reserved bits dropped
        '{10'h01E, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},  // R2 locked out
        '{10'h01F, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1}   // R8 foreign address
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic [7:0] d,
                            input logic unl, input logic pll);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; unlock_i = unl; pll_on_i = pll; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = REG_A;
        #0.5;
    endtask

    task automatic check_state(input string req, input logic w, input logic l);
        check(req, {24'd0, rd_data}, {29'd0, l, 1'b0, w});
        check(req, {31'd0, sfr_one_wait}, {31'd0, w});
        check("R6", {28'd0, wdt_src_ring, ring_osc_req, stop_bit_wr_block, wdt_keep_in_idle},
              {28'd0, l, l, l, l});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = REG_A; bus_wr = 1'b0; bus_wdata = '0;
        unlock_i = 1'b0; pll_on_i = 1'b0;
        do_reset();
        check_state("R1", 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].addr, VECS[i].data, VECS[i].unl, VECS[i].pll);
            check_state($sformatf("vec%0d", i), VECS[i].exp_wait, VECS[i].exp_lock);
        end

        // R8: foreign address read returns zero even with fields set
        bus_addr = 10'h01D; #0.5;
        check("R8", {24'd0, rd_data}, 32'h0);
        bus_addr = REG_A; #0.5;

        // R5: reset clears the sticky lock; R1 reset state again
        do_reset();
        check_state("R5", 1'b0, 1'b0);

        // R8: write at neighbouring address has no effect
        do_write(10'h01D, 8'h05, 1'b1, 1'b0);
        check_state("R8", 1'b0, 1'b0);

        // R7: all-ones write sets only the two live bits
        do_write(REG_A, 8'hFF, 1'b1, 1'b0);
        check("R7", {24'd0, rd_data}, 32'h05);

        // R2: locked-out write of zero keeps wait field at 1
        do_write(REG_A, 8'h00, 1'b0, 1'b0);
        check_state("R2", 1'b1, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule